// File: doc/BRIEF.md
# Bulk/Interrupt Endpoint Packet Segmenter

This block serves a single bulk or interrupt device endpoint. Software hands it one transfer: a total byte count, the endpoint's maximum packet length, a zero-length-termination control bit and a high-bandwidth multiplier field, which must be zero for this endpoint type. The block splits the transfer into a run of packets and answers each host token with either a NAK or the length of the packet to move next.

After a prime is accepted, the block works out the packet count and the length of the final packet. It does this with a subtract-and-compare loop, so no divider is needed. It then offers full-size packets until the last one, which carries the remainder. A packet only counts as moved once the host side reports an ACK handshake. A failed handshake leaves the same packet on offer. When the final packet is acknowledged, the block pulses a completion output and drops back to the unprimed state.

Bad configurations are rejected and flagged in a sticky status bit. A second prime that arrives while a transfer is pending is ignored and flagged in a separate sticky bit.

Top module: `ep_bulk_segmenter`

## Requirements
- R1: While the endpoint is not ready (unprimed, or still computing the packet plan), each token gets a response one clock later with `resp_valid`=1, `resp_nak`=1 and `resp_len`=0.
- R2: With the termination bit clear, the packet count is floor(bytes/mps)+1. Every packet but the last is mps long, and the last carries bytes mod mps, which is 0 when bytes is an exact multiple (e.g. 512@512 gives 512, 0).
- R3: With the termination bit set, the packet count is ceil(bytes/mps) and no trailing zero-length packet is produced. The last packet is mps long when bytes is an exact multiple (512@256 gives 256, 256).
- R4: A transfer of zero bytes produces exactly one zero-length packet, whatever the termination bit is set to.
- R5: One clock after the ACK of the final packet, `xfer_done` is high for one cycle and `ep_primed` is low. At that point `bytes_done` equals the byte count and `pkts_done` equals the packet count.
- R6: A handshake with `hs_ack`=0 leaves `bytes_done` and `pkts_done` unchanged, and the next token is offered the same length again.
- R7: A prime with a nonzero multiplier field, or with mps of 0 or above 1024, is rejected: the endpoint stays unprimed and `cfg_err` is set and held until reset.
- R8: A prime that arrives while the endpoint is primed is ignored: the transfer in progress continues unchanged, and `prime_err` is set and held until reset.
- R9: `ep_ready` rises no later than floor(bytes/mps)+2 clock edges after the edge that accepts the prime.
- R10: After the synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prime_valid | input | 1 | Prime request strobe |
| prime_bytes | input | 16 | Total transfer byte count |
| prime_mps | input | 11 | Maximum packet length, 1 to 1024 |
| prime_zlt | input | 1 | 1: no trailing zero-length packet on exact multiples |
| prime_mult | input | 2 | High-bandwidth multiplier; must be 0 |
| tok_valid | input | 1 | Host IN or OUT token seen for this endpoint |
| hs_valid | input | 1 | Handshake result strobe for the offered packet |
| hs_ack | input | 1 | 1: packet acknowledged, 0: failed or timed out |
| resp_valid | output | 1 | Token response strobe |
| resp_nak | output | 1 | 1: answer the token with NAK |
| resp_len | output | 11 | Length of the packet to move |
| ep_primed | output | 1 | A transfer is pending |
| ep_ready | output | 1 | Packet plan is computed and data may move |
| xfer_done | output | 1 | One-cycle pulse when the transfer retires |
| bytes_done | output | 16 | Bytes acknowledged in the current or last transfer |
| pkts_done | output | 17 | Packets acknowledged in the current or last transfer |
| cfg_err | output | 1 | Sticky: a prime was rejected for bad configuration |
| prime_err | output | 1 | Sticky: a prime arrived while already primed |

## Verification
A wrong iteration count or a wrong remainder in the plan computation first shows up in the length offered for the final packet, or as one packet too many or too few before `xfer_done`. So the packet-by-packet length sequence and the retirement cycle are checked for every transfer. Corrupted progress counters show up as wrong `bytes_done`/`pkts_done` right after each handshake, and as a completion pulse that is early, late or missing. A lost state transition shows up within one token as a NAK where data was expected, or the reverse.

// File: rtl/ep_seg_pkg.sv
package ep_seg_pkg;

    localparam int BYTE_W  = 16;
    localparam int LEN_W   = 11;
    localparam int MULT_W  = 2;
    localparam int MPS_MAX = 1024;
    localparam int PKT_W   = BYTE_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_ACTIVE
    } ep_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] bytes;
        logic [LEN_W-1:0]  mps;
        logic              zlt;
        logic [MULT_W-1:0] mult;
    } prime_req_t;

    typedef struct packed {
        logic             valid;
        logic             nak;
        logic [LEN_W-1:0] len;
    } tok_resp_t;

    typedef struct packed {
        logic [PKT_W-1:0] n_pkts;
        logic [LEN_W-1:0] last_len;
    } seg_plan_t;

    function automatic logic cfg_legal(prime_req_t r);
        return (r.mult == '0) && (r.mps != '0) && (r.mps <= LEN_W'(MPS_MAX));
    endfunction

endpackage

// File: rtl/ep_seg_calc.sv
module ep_seg_calc
    import ep_seg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  prime_req_t req,
    output logic       fin,
    output seg_plan_t  plan
);
    logic [BYTE_W-1:0] rem;
    logic [PKT_W-1:0]  cnt;
    logic [LEN_W-1:0]  mps_l;
    logic              zlt_l;
    logic              busy;
    logic              fits;

    assign fits = rem >= BYTE_W'(mps_l);
    assign fin  = busy && !fits;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            cnt   <= '0;
            mps_l <= '0;
            zlt_l <= 1'b0;
            busy  <= 1'b0;
            plan  <= '0;
        end else if (start) begin
            rem   <= req.bytes;
            cnt   <= '0;
            mps_l <= req.mps;
            zlt_l <= req.zlt;
            busy  <= 1'b1;
        end else if (busy) begin
            if (fits) begin
                rem <= rem - BYTE_W'(mps_l);
                cnt <= cnt + PKT_W'(1);
            end else begin
                busy <= 1'b0;
                if (rem == '0 && cnt != '0) begin
                    if (zlt_l) begin
                        plan.n_pkts   <= cnt;
                        plan.last_len <= mps_l;
                    end else begin
                        plan.n_pkts   <= cnt + PKT_W'(1);
                        plan.last_len <= '0;
                    end
                end else begin
                    plan.n_pkts   <= cnt + PKT_W'(1);
                    plan.last_len <= rem[LEN_W-1:0];
                end
            end
        end
    end

    // R9: each busy cycle with room left removes one full packet
    p_iter_step_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && fits && !start) |=> (cnt == $past(cnt) + PKT_W'(1)));

    // R2: the finished plan never holds a final packet longer than mps
    p_last_bound_r2: assert property (@(posedge clk) disable iff (rst)
        fin |=> (plan.last_len <= mps_l) && (plan.n_pkts != '0));

endmodule

// File: rtl/ep_seg_ctrl.sv
module ep_seg_ctrl
    import ep_seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prime_valid,
    input  prime_req_t        req,
    input  logic              calc_fin,
    input  seg_plan_t         plan,
    input  logic              hs_valid,
    input  logic              hs_ack,
    output logic              calc_start,
    output ep_state_e         state,
    output logic [LEN_W-1:0]  cur_len,
    output logic [LEN_W-1:0]  mps_q,
    output logic              xfer_done,
    output logic [BYTE_W-1:0] bytes_done,
    output logic [PKT_W-1:0]  pkts_done,
    output logic              cfg_err,
    output logic              prime_err
);
    logic last_pkt;
    logic acked;

    assign calc_start = prime_valid && (state == ST_IDLE) && cfg_legal(req);
    assign last_pkt   = pkts_done == (plan.n_pkts - PKT_W'(1));
    assign cur_len    = last_pkt ? plan.last_len : mps_q;
    assign acked      = (state == ST_ACTIVE) && hs_valid && hs_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            mps_q      <= '0;
            xfer_done  <= 1'b0;
            bytes_done <= '0;
            pkts_done  <= '0;
            cfg_err    <= 1'b0;
            prime_err  <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            if (prime_valid && state != ST_IDLE)
                prime_err <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (prime_valid) begin
                        if (calc_start) begin
                            state      <= ST_CALC;
                            mps_q      <= req.mps;
                            bytes_done <= '0;
                            pkts_done  <= '0;
                        end else begin
                            cfg_err <= 1'b1;
                        end
                    end
                end
                ST_CALC: begin
                    if (calc_fin)
                        state <= ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (acked) begin
                        bytes_done <= bytes_done + BYTE_W'(cur_len);
                        pkts_done  <= pkts_done + PKT_W'(1);
                        if (last_pkt) begin
                            xfer_done <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: a prime while primed raises the sticky flag
    p_reprime_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (prime_valid && state != ST_IDLE) |=> prime_err);

    // R7: an illegal prime leaves the endpoint idle and flagged
    p_cfg_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (prime_valid && state == ST_IDLE && !cfg_legal(req))
        |=> (state == ST_IDLE) && cfg_err);

    // R6: a failed handshake moves no counter
    p_nack_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && hs_valid && !hs_ack)
        |=> $stable(pkts_done) && $stable(bytes_done));

    // R5: progress never passes the planned packet count
    p_pkt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE) |-> (pkts_done < plan.n_pkts));

    // R5: the completion pulse leaves the endpoint idle
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (state == ST_IDLE));

endmodule

// File: rtl/ep_seg_resp.sv
module ep_seg_resp
    import ep_seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_valid,
    input  logic             ready,
    input  logic [LEN_W-1:0] cur_len,
    output tok_resp_t        resp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp.valid <= tok_valid;
            resp.nak   <= tok_valid && !ready;
            resp.len   <= (tok_valid && ready) ? cur_len : '0;
        end
    end

    // R1: a token seen before the plan is ready is refused
    p_nak_unready_r1: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !ready) |=> resp.valid && resp.nak && (resp.len == '0));

endmodule

// File: rtl/ep_bulk_segmenter.sv
module ep_bulk_segmenter
    import ep_seg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      prime_valid,
    input  logic [BYTE_W-1:0]         prime_bytes,
    input  logic [LEN_W-1:0]          prime_mps,
    input  logic                      prime_zlt,
    input  logic [MULT_W-1:0]         prime_mult,
    input  logic                      tok_valid,
    input  logic                      hs_valid,
    input  logic                      hs_ack,
    output logic                      resp_valid,
    output logic                      resp_nak,
    output logic [LEN_W-1:0]          resp_len,
    output logic                      ep_primed,
    output logic                      ep_ready,
    output logic                      xfer_done,
    output logic [BYTE_W-1:0]         bytes_done,
    output logic [PKT_W-1:0]          pkts_done,
    output logic                      cfg_err,
    output logic                      prime_err
);
    prime_req_t       req;
    seg_plan_t        plan;
    tok_resp_t        resp;
    ep_state_e        state;
    logic             calc_start;
    logic             calc_fin;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] mps_q;

    assign req = '{bytes: prime_bytes, mps: prime_mps, zlt: prime_zlt, mult: prime_mult};

    ep_seg_calc u_calc (
        .clk   (clk),
        .rst   (rst),
        .start (calc_start),
        .req   (req),
        .fin   (calc_fin),
        .plan  (plan)
    );

    ep_seg_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .prime_valid(prime_valid),
        .req        (req),
        .calc_fin   (calc_fin),
        .plan       (plan),
        .hs_valid   (hs_valid),
        .hs_ack     (hs_ack),
        .calc_start (calc_start),
        .state      (state),
        .cur_len    (cur_len),
        .mps_q      (mps_q),
        .xfer_done  (xfer_done),
        .bytes_done (bytes_done),
        .pkts_done  (pkts_done),
        .cfg_err    (cfg_err),
        .prime_err  (prime_err)
    );

    assign ep_primed = state != ST_IDLE;
    assign ep_ready  = state == ST_ACTIVE;

    ep_seg_resp u_resp (
        .clk      (clk),
        .rst      (rst),
        .tok_valid(tok_valid),
        .ready    (ep_ready),
        .cur_len  (cur_len),
        .resp     (resp)
    );

    assign resp_valid = resp.valid;
    assign resp_nak   = resp.nak;
    assign resp_len   = resp.len;

    // R2: an offered data length never exceeds the primed maximum
    p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_nak) |-> (resp_len <= mps_q));

    // R5: a transfer that retires has moved at least one packet
    p_done_count_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (pkts_done != '0) && !ep_primed);

endmodule

// File: tb/test_ep_bulk_segmenter.sv
module test_ep_bulk_segmenter;
    localparam int CLK_P = 10;
    localparam int NV    = 12;
    // bytes[66:51] mps[50:40] zlt[39] n[38:22] first[21:11] last[10:0]
    localparam logic [66:0] VEC [NV] = '{
        {16'd511,   11'd256,  1'b0, 17'd2,  11'd256,  11'd255},
        {16'd512,   11'd256,  1'b0, 17'd3,  11'd256,  11'd0},
        {16'd512,   11'd512,  1'b0, 17'd2,  11'd512,  11'd0},
        {16'd511,   11'd256,  1'b1, 17'd2,  11'd256,  11'd255},
        {16'd512,   11'd256,  1'b1, 17'd2,  11'd256,  11'd256},
        {16'd512,   11'd512,  1'b1, 17'd1,  11'd512,  11'd512},
        {16'd0,     11'd64,   1'b0, 17'd1,  11'd0,    11'd0},
        {16'd0,     11'd64,   1'b1, 17'd1,  11'd0,    11'd0},
        {16'd100,   11'd1024, 1'b1, 17'd1,  11'd100,  11'd100},
        {16'd10,    11'd3,    1'b0, 17'd4,  11'd3,    11'd1},
        {16'd2048,  11'd1024, 1'b0, 17'd3,  11'd1024, 11'd0},
        {16'd65535, 11'd1024, 1'b1, 17'd64, 11'd1024, 11'd1023}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        prime_valid = 0;
    logic [15:0] prime_bytes = 0;
    logic [10:0] prime_mps = 0;
    logic        prime_zlt = 0;
    logic [1:0]  prime_mult = 0;
    logic        tok_valid = 0;
    logic        hs_valid = 0;
    logic        hs_ack = 0;
    logic        resp_valid, resp_nak, ep_primed, ep_ready, xfer_done, cfg_err, prime_err;
    logic [10:0] resp_len;
    logic [15:0] bytes_done;
    logic [16:0] pkts_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    ep_bulk_segmenter i_ep_bulk_segmenter (
        .clk(clk), .rst(rst), .prime_valid(prime_valid), .prime_bytes(prime_bytes),
        .prime_mps(prime_mps), .prime_zlt(prime_zlt), .prime_mult(prime_mult),
        .tok_valid(tok_valid), .hs_valid(hs_valid), .hs_ack(hs_ack),
        .resp_valid(resp_valid), .resp_nak(resp_nak), .resp_len(resp_len),
        .ep_primed(ep_primed), .ep_ready(ep_ready), .xfer_done(xfer_done),
        .bytes_done(bytes_done), .pkts_done(pkts_done), .cfg_err(cfg_err),
        .prime_err(prime_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1;
        @(negedge clk);
        @(negedge clk) rst = 0;
    endtask

    task automatic prime(input int b, input int m, input bit z, input int mu);
        @(negedge clk);
        prime_valid = 1; prime_bytes = 16'(b); prime_mps = 11'(m);
        prime_zlt = z; prime_mult = 2'(mu);
        @(negedge clk) prime_valid = 0;
    endtask

    task automatic token();
        @(negedge clk) tok_valid = 1;
        @(negedge clk) tok_valid = 0;
    endtask

    task automatic handshake(input bit a);
        @(negedge clk) begin hs_valid = 1; hs_ack = a; end
        @(negedge clk) hs_valid = 0;
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 1;
        while (!ep_ready && cyc < 70000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic expect_data(input string req, input int len);
        token();
        chk(resp_valid && !resp_nak, req, "data response", int'(resp_nak), 0);
        chk(resp_len == 11'(len), req, "packet length", int'(resp_len), len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(!resp_valid && !resp_nak && resp_len == 0, "R10", "response idle", int'(resp_valid), 0);
        chk(!ep_primed && !ep_ready && !xfer_done, "R10", "endpoint idle", int'(ep_primed), 0);
        chk(bytes_done == 0 && pkts_done == 0, "R10", "counters", int'(pkts_done), 0);
        chk(!cfg_err && !prime_err, "R10", "error flags", int'(cfg_err), 0);

        // table-driven transfers: R1 R2 R3 R4 R5 R9
        for (int v = 0; v < NV; v++) begin
            automatic int b  = int'(VEC[v][66:51]);
            automatic int m  = int'(VEC[v][50:40]);
            automatic bit z  = VEC[v][39];
            automatic int n  = int'(VEC[v][38:22]);
            automatic int f  = int'(VEC[v][21:11]);
            automatic int l  = int'(VEC[v][10:0]);
            automatic int cyc;
            string rq;
            rq = (b == 0) ? "R4" : (z ? "R3" : "R2");
            token();
            chk(resp_valid && resp_nak && resp_len == 0, "R1", "unprimed NAK", int'(resp_nak), 1);
            prime(b, m, z, 0);
            wait_ready(cyc);
            chk(ep_ready && cyc <= b / m + 2, "R9", "ready latency", cyc, b / m + 2);
            for (int p = 0; p < n; p++) begin
                expect_data(rq, (p == n - 1) ? l : f);
                handshake(1);
                if (p < n - 1)
                    chk(pkts_done == 17'(p + 1) && !xfer_done, "R5", "packets done", int'(pkts_done), p + 1);
            end
            chk(xfer_done, "R5", "completion pulse", int'(xfer_done), 1);
            chk(!ep_primed, "R5", "unprimed after retire", int'(ep_primed), 0);
            chk(bytes_done == 16'(b), "R5", "bytes done", int'(bytes_done), b);
            chk(pkts_done == 17'(n), "R5", "packet count", int'(pkts_done), n);
            @(negedge clk);
            chk(!xfer_done, "R5", "pulse one cycle", int'(xfer_done), 0);
        end
        chk(!cfg_err && !prime_err, "R7", "no spurious error", int'(cfg_err), 0);

        // R1: token during plan computation
        prime(3000, 1, 0, 0);
        token();
        chk(resp_valid && resp_nak, "R1", "NAK while computing", int'(resp_nak), 1);
        do_reset();

        // R6: failed handshake re-offers same packet
        prime(300, 256, 0, 0);
        begin
            int cyc;
            wait_ready(cyc);
        end
        expect_data("R6", 256);
        handshake(0);
        chk(pkts_done == 0 && bytes_done == 0, "R6", "counters held", int'(bytes_done), 0);
        expect_data("R6", 256);
        handshake(1);
        expect_data("R6", 44);
        handshake(0);
        chk(pkts_done == 1 && bytes_done == 256 && ep_primed, "R6", "held on last", int'(bytes_done), 256);
        expect_data("R6", 44);
        handshake(1);
        chk(xfer_done && bytes_done == 300, "R6", "retired after retry", int'(bytes_done), 300);

        // R8: prime while primed is ignored
        prime(600, 256, 0, 0);
        begin
            int cyc;
            wait_ready(cyc);
        end
        expect_data("R8", 256);
        handshake(1);
        chk(!prime_err, "R8", "flag clear before", int'(prime_err), 0);
        prime(10, 5, 1, 0);
        chk(prime_err, "R8", "sticky flag", int'(prime_err), 1);
        expect_data("R8", 256);
        handshake(1);
        expect_data("R8", 88);
        handshake(1);
        chk(xfer_done && pkts_done == 3, "R8", "original transfer kept", int'(pkts_done), 3);
        @(negedge clk);
        chk(prime_err, "R8", "flag held", int'(prime_err), 1);

        // R7: illegal configurations
        do_reset();
        prime(64, 64, 0, 2);
        chk(cfg_err && !ep_primed, "R7", "nonzero multiplier", int'(cfg_err), 1);
        token();
        chk(resp_nak, "R7", "still NAK", int'(resp_nak), 1);
        prime(64, 64, 0, 0);
        chk(cfg_err && ep_primed, "R7", "flag sticky, good prime taken", int'(cfg_err), 1);
        do_reset();
        prime(64, 0, 0, 0);
        chk(cfg_err && !ep_primed, "R7", "mps zero", int'(cfg_err), 1);
        do_reset();
        prime(64, 1025, 0, 0);
        chk(cfg_err && !ep_primed, "R7", "mps too large", int'(cfg_err), 1);
        do_reset();
        prime(64, 1024, 0, 0);
        chk(!cfg_err && ep_primed, "R7", "mps 1024 legal", int'(cfg_err), 0);

        finished = 1;
        summary();
    end
endmodule